// File: doc/BRIEF.md
# Platform Power State Sequencer

This block is a synchronous state machine that follows the combined sleep and processor-idle state of a platform. It holds one of nine states: four working states (C0 running, and the idle levels C2, C3 and C4), three sleeping states (S1, S3, S4), soft-off (S5) and mechanical-off (G3). It changes state in response to single-cycle event pulses and a few level inputs. It reports the current state as a one-hot vector and gives a one-cycle pulse whenever the state changes.

Idle levels are entered by stepping deeper from C0. The machine leaves an idle level when a break or bus-master event arrives. A small history register records whether C2 was reached from a deeper level, so the machine can fall back into C3 or C4 once bus masters go quiet. Every return from sleep or off into C0 is held back while the low-battery level is high. Such a request is kept pending and completes on the first clock edge at which the low-battery level is low.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset, and after any later reset, the state is G3 and `state_chg` is 0. `state_oh` always has exactly one bit set, with bit positions 0=C0, 1=C2, 2=C3, 3=C4, 4=S1, 5=S3, 6=S4, 7=S5, 8=G3.
- R2: `pfail_evt` moves the machine to G3 from every state, overriding all other inputs. It also discards any pending deferred wake.
- R3: `pbo_evt` moves the machine to S5 from every state except G3, overriding everything except power failure.
- R4: In C2, C3 or C4, `brk_evt` moves the machine to C0, overriding a bus-master event and idle re-entry in the same cycle.
- R5: In C0, `sleep_req` moves the machine to the state coded on `sleep_tgt` (00=S1, 01=S3, 10=S4, 11=S5) and wins over `idle_req`. `idle_req` alone moves C0 to C2. Break, bus-master and wake events have no effect in C0.
- R6: In C3 or C4, `bm_evt` moves the machine to C2 when `bm_to_c2` is 1 and to C0 when it is 0.
- R7: In C2 reached from C3 or C4, a high `bm_idle` returns the machine to C4 if `deep_sel` is 1, or to C3 if it is 0. In C2 entered from C0, `bm_idle` has no effect. There, `idle_req` steps to C4 or C3 by `deep_sel`.
- R8: In C3, if C4 was visited since C2 was last entered from C0, then `bm_idle` together with `deep_sel`=1 moves the machine to C4.
- R9: In S1, S3, S4 or S5, `wake_evt` moves the machine to C0.
- R10: In G3, `pret_evt` moves the machine to C0 when `ret_on` is 1 and to S5 when it is 0.
- R11: While `batt_low` is 1, no transition from sleep or off into C0 happens. The request stays pending, including across a power-button override. It completes at the first edge at which `batt_low` is 0.
- R12: `state_chg` is 1 for exactly the cycles in which the state differs from its value one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brk_evt | input | 1 | Enabled break event pulse |
| bm_evt | input | 1 | Bus-master activity event pulse |
| wake_evt | input | 1 | Enabled wake event pulse |
| pbo_evt | input | 1 | Power-button override pulse |
| pfail_evt | input | 1 | Power failure pulse |
| pret_evt | input | 1 | Power return pulse |
| bm_idle | input | 1 | Bus masters idle level |
| batt_low | input | 1 | Low-battery level, defers exits to C0 |
| deep_sel | input | 1 | Deep idle select: 1=C4, 0=C3 |
| bm_to_c2 | input | 1 | Bus-master exit target: 1=C2, 0=C0 |
| ret_on | input | 1 | Power-return target: 1=C0, 0=S5 |
| sleep_req | input | 1 | Sleep entry request from C0 |
| sleep_tgt | input | 2 | Sleep target code |
| idle_req | input | 1 | Step one idle level deeper |
| state_oh | output | 9 | One-hot current state |
| state_chg | output | 1 | State changed on the last edge |

## Verification
The hardest case to reach is the fall from C3 back into C4. It needs a history that names C4 while the machine sits in C3. The stimulus first enters C4, leaves it to C2 on a bus-master event, then lets C2 fall into C3 with `deep_sel` low, and finally raises `deep_sel` with bus masters still idle. The second hard case is a deferred wake that must survive a power-button override. The bench issues a wake under low battery, applies an override to S5 while the battery stays low, and then releases the battery level to see the pending wake complete.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  localparam int NUM_ST  = 9;
  localparam int ST_W    = 4;
  localparam int TGT_W   = 2;

  typedef enum logic [ST_W-1:0] {
    ST_C0 = 4'd0,
    ST_C2 = 4'd1,
    ST_C3 = 4'd2,
    ST_C4 = 4'd3,
    ST_S1 = 4'd4,
    ST_S3 = 4'd5,
    ST_S4 = 4'd6,
    ST_S5 = 4'd7,
    ST_G3 = 4'd8
  } pwr_st_e;

  typedef enum logic [1:0] {
    HIST_NONE = 2'd0,
    HIST_C3   = 2'd1,
    HIST_C4   = 2'd2
  } idle_hist_e;

  // Processor idle levels below C0.
  function automatic logic is_idle(input pwr_st_e s);
    return (s == ST_C2) || (s == ST_C3) || (s == ST_C4);
  endfunction

  // Sleeping or soft-off: a wake event leads back to C0.
  function automatic logic is_asleep(input pwr_st_e s);
    return (s == ST_S1) || (s == ST_S3) || (s == ST_S4) || (s == ST_S5);
  endfunction

  // Any non-working state; exits from these are subject to deferral.
  function automatic logic is_rest(input pwr_st_e s);
    return is_asleep(s) || (s == ST_G3);
  endfunction

  function automatic pwr_st_e sleep_target(input logic [TGT_W-1:0] code);
    case (code)
      2'b00:   return ST_S1;
      2'b01:   return ST_S3;
      2'b10:   return ST_S4;
      default: return ST_S5;
    endcase
  endfunction

  function automatic pwr_st_e deep_pick(input logic deep);
    return deep ? ST_C4 : ST_C3;
  endfunction

  function automatic pwr_st_e bm_exit(input logic to_c2);
    return to_c2 ? ST_C2 : ST_C0;
  endfunction

  function automatic logic [NUM_ST-1:0] st_onehot(input pwr_st_e s);
    logic [NUM_ST-1:0] r;
    r = '0;
    r[int'(s)] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/pwr_wake_defer.sv
module pwr_wake_defer (
  input  logic clk,
  input  logic rst_n,
  input  logic in_rest,
  input  logic exit_req,
  input  logic batt_low,
  input  logic pfail,
  input  logic pbo,
  output logic exit_go,
  output logic pend_q
);

  logic want;
  logic pend_d;

  assign want    = in_rest && (exit_req || pend_q);
  assign exit_go = want && !batt_low && !pfail && !pbo;

  always_comb begin
    pend_d = pend_q;
    if (pfail || !in_rest)         pend_d = 1'b0;
    else if (exit_go)              pend_d = 1'b0;
    else if (exit_req)             pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/pwr_idle_hist.sv
module pwr_idle_hist
  import pwr_state_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_st_e    cur,
  input  pwr_st_e    nxt,
  output idle_hist_e hist_q
);

  idle_hist_e hist_d;

  always_comb begin
    hist_d = hist_q;
    if (nxt != cur) begin
      if (!is_idle(nxt)) begin
        hist_d = HIST_NONE;
      end else begin
        case (cur)
          ST_C4:   hist_d = HIST_C4;
          ST_C3:   hist_d = (hist_q == HIST_C4) ? HIST_C4 : HIST_C3;
          ST_C2:   hist_d = hist_q;
          default: hist_d = HIST_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= HIST_NONE;
    else        hist_q <= hist_d;
  end

endmodule

// File: rtl/pwr_next_state.sv
module pwr_next_state
  import pwr_state_pkg::*;
(
  input  pwr_st_e          cur,
  input  idle_hist_e       hist,
  input  logic             pfail,
  input  logic             pbo_eff,
  input  logic             brk,
  input  logic             bm,
  input  logic             pret,
  input  logic             exit_go,
  input  logic             bm_idle,
  input  logic             deep_sel,
  input  logic             bm_to_c2,
  input  logic             ret_on,
  input  logic             sleep_req,
  input  logic [TGT_W-1:0] sleep_tgt,
  input  logic             idle_req,
  output pwr_st_e          nxt
);

  logic c2_fall;
  logic c3_fall;

  assign c2_fall = (hist != HIST_NONE) && bm_idle;
  assign c3_fall = (hist == HIST_C4) && bm_idle && deep_sel;

  always_comb begin
    nxt = cur;
    if (pfail) begin
      nxt = ST_G3;
    end else if (pbo_eff) begin
      nxt = ST_S5;
    end else begin
      case (cur)
        ST_C0: begin
          if (sleep_req)     nxt = sleep_target(sleep_tgt);
          else if (idle_req) nxt = ST_C2;
        end
        ST_C2: begin
          if (brk)           nxt = ST_C0;
          else if (c2_fall)  nxt = deep_pick(deep_sel);
          else if (idle_req) nxt = deep_pick(deep_sel);
        end
        ST_C3: begin
          if (brk)           nxt = ST_C0;
          else if (bm)       nxt = bm_exit(bm_to_c2);
          else if (c3_fall)  nxt = ST_C4;
        end
        ST_C4: begin
          if (brk)           nxt = ST_C0;
          else if (bm)       nxt = bm_exit(bm_to_c2);
        end
        ST_S1, ST_S3, ST_S4, ST_S5: begin
          if (exit_go)       nxt = ST_C0;
        end
        ST_G3: begin
          if (exit_go)             nxt = ST_C0;
          else if (pret && !ret_on) nxt = ST_S5;
        end
        default: nxt = ST_G3;
      endcase
    end
  end

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_evt,
  input  logic              bm_evt,
  input  logic              wake_evt,
  input  logic              pbo_evt,
  input  logic              pfail_evt,
  input  logic              pret_evt,
  input  logic              bm_idle,
  input  logic              batt_low,
  input  logic              deep_sel,
  input  logic              bm_to_c2,
  input  logic              ret_on,
  input  logic              sleep_req,
  input  logic [TGT_W-1:0]  sleep_tgt,
  input  logic              idle_req,
  output logic [NUM_ST-1:0] state_oh,
  output logic              state_chg
);

  pwr_st_e    cur_q;
  pwr_st_e    nxt;
  idle_hist_e hist_q;

  // Named internal events, also observed by the bound checker.
  logic in_rest;
  logic pbo_eff;
  logic exit_req;
  logic exit_go;
  logic pend_q;

  assign in_rest  = is_rest(cur_q);
  assign pbo_eff  = pbo_evt && (cur_q != ST_G3);
  assign exit_req = (is_asleep(cur_q) && wake_evt) ||
                    ((cur_q == ST_G3) && pret_evt && ret_on);

  pwr_wake_defer u_defer (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_rest  (in_rest),
    .exit_req (exit_req),
    .batt_low (batt_low),
    .pfail    (pfail_evt),
    .pbo      (pbo_eff),
    .exit_go  (exit_go),
    .pend_q   (pend_q)
  );

  pwr_idle_hist u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .cur    (cur_q),
    .nxt    (nxt),
    .hist_q (hist_q)
  );

  pwr_next_state u_next (
    .cur       (cur_q),
    .hist      (hist_q),
    .pfail     (pfail_evt),
    .pbo_eff   (pbo_eff),
    .brk       (brk_evt),
    .bm        (bm_evt),
    .pret      (pret_evt),
    .exit_go   (exit_go),
    .bm_idle   (bm_idle),
    .deep_sel  (deep_sel),
    .bm_to_c2  (bm_to_c2),
    .ret_on    (ret_on),
    .sleep_req (sleep_req),
    .sleep_tgt (sleep_tgt),
    .idle_req  (idle_req),
    .nxt       (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q     <= ST_G3;
      state_chg <= 1'b0;
    end else begin
      cur_q     <= nxt;
      state_chg <= (nxt != cur_q);
    end
  end

  assign state_oh = st_onehot(cur_q);

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       brk_evt,
  input logic       pbo_evt,
  input logic       pfail_evt,
  input logic       batt_low,
  input logic [8:0] state_oh,
  input logic       state_chg,
  input logic       exit_go,
  input logic       pend_q
);

  AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_oh) == 1); // R1

  AST_PFAIL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pfail_evt |=> state_oh[8]); // R2

  AST_PFAIL_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    pfail_evt |=> !pend_q); // R2

  AST_OVR_SOFT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pbo_evt && !pfail_evt && !state_oh[8]) |=> state_oh[7]); // R3

  AST_BREAK_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_evt && !pfail_evt && !pbo_evt && (|state_oh[3:1])) |=> state_oh[0]); // R4

  AST_BATT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_low && (|state_oh[8:4])) |=> !state_oh[0]); // R11

  AST_GO_NEEDS_BATT: assert property (@(posedge clk) disable iff (!rst_n)
    exit_go |-> !batt_low); // R11

  AST_CHG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    state_chg == (state_oh != $past(state_oh))); // R12

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .brk_evt   (brk_evt),
  .pbo_evt   (pbo_evt),
  .pfail_evt (pfail_evt),
  .batt_low  (batt_low),
  .state_oh  (state_oh),
  .state_chg (state_chg),
  .exit_go   (exit_go),
  .pend_q    (pend_q)
);

// File: tb/pwr_state_ctrl_tb.sv
module pwr_state_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  // Bench-side state positions (from R1).
  localparam int X_C0 = 0, X_C2 = 1, X_C3 = 2, X_C4 = 3;
  localparam int X_S1 = 4, X_S3 = 5, X_S4 = 6, X_S5 = 7, X_G3 = 8;

  // Event masks.
  localparam logic [7:0] E_NONE = 8'h00, E_BRK = 8'h01, E_BM = 8'h02, E_WAKE = 8'h04;
  localparam logic [7:0] E_PBO = 8'h08, E_PF = 8'h10, E_PRET = 8'h20, E_SREQ = 8'h40;
  localparam logic [7:0] E_IREQ = 8'h80;

  // cfg = {bm_idle, batt_low, deep_sel, bm_to_c2, ret_on}
  typedef struct packed {
    logic [7:0] ev;
    logic [4:0] cfg;
    logic [1:0] tgt;
    logic [3:0] exp;
    logic       chg;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VECS [NV] = '{
    '{E_PRET, 5'b00001, 2'd0, 4'(X_C0), 1'b1, 4'd10}, // R10 return to run
    '{E_NONE, 5'b00000, 2'd0, 4'(X_C0), 1'b0, 4'd12}, // R12 no change
    '{E_BRK,  5'b00000, 2'd0, 4'(X_C0), 1'b0, 4'd5},  // R5 ignored in C0
    '{E_IREQ, 5'b00000, 2'd0, 4'(X_C2), 1'b1, 4'd5},
    '{E_NONE, 5'b10100, 2'd0, 4'(X_C2), 1'b0, 4'd7},  // R7 no history
    '{E_IREQ, 5'b00100, 2'd0, 4'(X_C4), 1'b1, 4'd7},
    '{E_BM,   5'b00010, 2'd0, 4'(X_C2), 1'b1, 4'd6},  // R6
    '{E_NONE, 5'b00000, 2'd0, 4'(X_C2), 1'b0, 4'd7},
    '{E_NONE, 5'b10000, 2'd0, 4'(X_C3), 1'b1, 4'd7},
    '{E_NONE, 5'b10100, 2'd0, 4'(X_C4), 1'b1, 4'd8},  // R8
    '{E_BM,   5'b00000, 2'd0, 4'(X_C0), 1'b1, 4'd6},
    '{E_IREQ, 5'b00000, 2'd0, 4'(X_C2), 1'b1, 4'd5},
    '{E_IREQ, 5'b00000, 2'd0, 4'(X_C3), 1'b1, 4'd7},
    '{E_BM,   5'b00010, 2'd0, 4'(X_C2), 1'b1, 4'd6},
    '{E_NONE, 5'b10100, 2'd0, 4'(X_C4), 1'b1, 4'd7},
    '{E_BRK,  5'b00000, 2'd0, 4'(X_C0), 1'b1, 4'd4},  // R4
    '{E_SREQ, 5'b00000, 2'd0, 4'(X_S1), 1'b1, 4'd5},
    '{E_WAKE, 5'b00000, 2'd0, 4'(X_C0), 1'b1, 4'd9},  // R9
    '{E_SREQ, 5'b00000, 2'd1, 4'(X_S3), 1'b1, 4'd5},
    '{E_WAKE, 5'b01000, 2'd0, 4'(X_S3), 1'b0, 4'd11}, // R11 deferred
    '{E_NONE, 5'b01000, 2'd0, 4'(X_S3), 1'b0, 4'd11},
    '{E_NONE, 5'b00000, 2'd0, 4'(X_C0), 1'b1, 4'd11},
    '{E_SREQ, 5'b00000, 2'd2, 4'(X_S4), 1'b1, 4'd5},
    '{E_PBO,  5'b00000, 2'd0, 4'(X_S5), 1'b1, 4'd3},  // R3
    '{E_WAKE, 5'b00000, 2'd0, 4'(X_C0), 1'b1, 4'd9},
    '{E_SREQ, 5'b00000, 2'd3, 4'(X_S5), 1'b1, 4'd5},
    '{E_PF,   5'b00000, 2'd0, 4'(X_G3), 1'b1, 4'd2},  // R2
    '{E_PRET, 5'b00000, 2'd0, 4'(X_S5), 1'b1, 4'd10},
    '{E_PF,   5'b00000, 2'd0, 4'(X_G3), 1'b1, 4'd2},
    '{E_PF,   5'b00000, 2'd0, 4'(X_G3), 1'b0, 4'd12},
    '{E_PRET, 5'b01001, 2'd0, 4'(X_G3), 1'b0, 4'd11},
    '{E_PF,   5'b01000, 2'd0, 4'(X_G3), 1'b0, 4'd2},
    '{E_NONE, 5'b00000, 2'd0, 4'(X_G3), 1'b0, 4'd2},  // pending dropped
    '{E_PRET, 5'b00001, 2'd0, 4'(X_C0), 1'b1, 4'd10}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       brk_evt, bm_evt, wake_evt, pbo_evt, pfail_evt, pret_evt;
  logic       bm_idle, batt_low, deep_sel, bm_to_c2, ret_on;
  logic       sleep_req, idle_req;
  logic [1:0] sleep_tgt;
  logic [8:0] state_oh;
  logic       state_chg;

  int n_vec  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .brk_evt   (brk_evt),
    .bm_evt    (bm_evt),
    .wake_evt  (wake_evt),
    .pbo_evt   (pbo_evt),
    .pfail_evt (pfail_evt),
    .pret_evt  (pret_evt),
    .bm_idle   (bm_idle),
    .batt_low  (batt_low),
    .deep_sel  (deep_sel),
    .bm_to_c2  (bm_to_c2),
    .ret_on    (ret_on),
    .sleep_req (sleep_req),
    .sleep_tgt (sleep_tgt),
    .idle_req  (idle_req),
    .state_oh  (state_oh),
    .state_chg (state_chg)
  );

  task automatic clear_events();
    brk_evt = 0; bm_evt = 0; wake_evt = 0; pbo_evt = 0;
    pfail_evt = 0; pret_evt = 0; sleep_req = 0; idle_req = 0;
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic [7:0] ev, input logic [4:0] cfg, input logic [1:0] tgt);
    brk_evt   = ev[0]; bm_evt    = ev[1]; wake_evt  = ev[2]; pbo_evt   = ev[3];
    pfail_evt = ev[4]; pret_evt  = ev[5]; sleep_req = ev[6]; idle_req  = ev[7];
    bm_idle   = cfg[4]; batt_low = cfg[3]; deep_sel = cfg[2];
    bm_to_c2  = cfg[1]; ret_on   = cfg[0]; sleep_tgt = tgt;
    @(posedge clk);
    @(negedge clk);
    clear_events();
  endtask

  task automatic check(input int idx, input logic chg, input string tag);
    logic [8:0] exp_oh;
    exp_oh = 9'd1 << idx;
    n_vec++;
    if (state_oh !== exp_oh || state_chg !== chg) begin
      n_fail++;
      $display("FAIL %s: state_oh=%b chg=%b expected state_oh=%b chg=%b",
               tag, state_oh, state_chg, exp_oh, chg);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0;
    clear_events();
    bm_idle = 0; batt_low = 0; deep_sel = 0; bm_to_c2 = 0; ret_on = 0; sleep_tgt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(X_G3, 1'b0, "R1 reset state");

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].ev, VECS[i].cfg, VECS[i].tgt);
      check(int'(VECS[i].exp), VECS[i].chg, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R4: break beats bus-master in C4
    step(E_IREQ, 5'b00000, 2'd0);          check(X_C2, 1'b1, "R4 setup C2");
    step(E_IREQ, 5'b00100, 2'd0);          check(X_C4, 1'b1, "R4 setup C4");
    step(E_BRK | E_BM, 5'b00010, 2'd0);    check(X_C0, 1'b1, "R4 break over bus-master");

    // R3: override beats break in C3
    step(E_IREQ, 5'b00000, 2'd0);          check(X_C2, 1'b1, "R3 setup C2");
    step(E_IREQ, 5'b00000, 2'd0);          check(X_C3, 1'b1, "R3 setup C3");
    step(E_PBO | E_BRK, 5'b00000, 2'd0);   check(X_S5, 1'b1, "R3 override over break");

    // R2: power failure beats wake in S5
    step(E_PF | E_WAKE, 5'b00000, 2'd0);   check(X_G3, 1'b1, "R2 failure over wake");
    step(E_PRET, 5'b00001, 2'd0);          check(X_C0, 1'b1, "R10 power return to C0");

    // R5: sleep request wins over idle request
    step(E_SREQ | E_IREQ, 5'b00000, 2'd1); check(X_S3, 1'b1, "R5 sleep over idle");

    // R11: deferred wake survives an override
    step(E_WAKE, 5'b01000, 2'd0);          check(X_S3, 1'b0, "R11 wake held");
    step(E_PBO, 5'b01000, 2'd0);           check(X_S5, 1'b1, "R11 override while pending");
    step(E_NONE, 5'b01000, 2'd0);          check(X_S5, 1'b0, "R11 still held");
    step(E_NONE, 5'b00000, 2'd0);          check(X_C0, 1'b1, "R11 pending wake completes");

    // R1: reset in mid-run
    step(E_IREQ, 5'b00000, 2'd0);          check(X_C2, 1'b1, "R1 setup C2");
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    check(X_G3, 1'b0, "R1 mid-run reset");
    rst_n = 1;
    step(E_NONE, 5'b10100, 2'd0);          check(X_G3, 1'b0, "R1 stays off after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule